// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutator

This block turns the three Hall-effect rotor-position signals of a brushless motor into gate commands for a three-phase bridge. The Hall levels are first brought into the clock domain and then debounced by a counting filter. Each legal level pattern names one of six 60-degree electrical sectors. The sector, shifted by an alignment offset and optionally by half a turn for reverse drive, selects one high-side and one low-side switch. The third phase is left floating with both of its switches off.

The active high-side switch is chopped by an external PWM input, and the duty of that input sets the average winding voltage. The low-side switch stays on for the whole sector. The block also reports the decoded sector, a one-cycle pulse on every sector change and the observed rotation direction. Two sticky flags report forbidden Hall patterns and transitions that jump over a sector. Every pin is a plain level control or status signal; there is no streaming interface and no back-pressure.

Top module: `hall_commutator`

## Requirements
- R1: A new Hall pattern is accepted only after it has been sampled unchanged for FILT_CYCLES consecutive clocks after the synchroniser (default 4). A pulse shorter than that leaves every output unchanged.
- R2: Accepted codes `{hall_in[2],hall_in[1],hall_in[0]}` decode to sector numbers 0 to 5 as follows: 001→0, 011→1, 010→2, 110→3, 100→4, 101→5. The decoded value is shown on `sector`.
- R3: Drive state s = (sector + offset + (dir_rev ? 3 : 0)) mod 6. Bus bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. The phases driven in each state are, as (high phase, low phase): s0 = (A,B), s1 = (A,C), s2 = (B,C), s3 = (B,A), s4 = (C,A), s5 = (C,B).
- R4: The selected high-side bit equals `pwm_in` as sampled one clock earlier. The low-side bit is not gated by PWM.
- R5: At most one `gate_hi` bit and at most one `gate_lo` bit are set at any time. Both switches of the same phase are never on together, so one phase always floats.
- R6: When `enable` is low, every gate output is 0 on the following clock.
- R7: Setting `dir_rev` adds three to the drive state, which swaps the high and low phases of the forward choice.
- R8: `sec_ofs` values 0 to 5 are used as given. Values 6 and 7 act as 0 and 1.
- R9: An accepted pattern of 000 or 111 turns off all gates and sets `hall_fault`. The flag and the forced-off gates remain until reset, even after valid codes return.
- R10: An accepted change between two valid codes that differ in more than one bit sets the sticky `seq_err` flag. The gates then follow the new sector.
- R11: `sector_chg` is high for exactly one clock for every accepted change between two valid codes. It stays low when a code is first accepted after reset and when the change involves an invalid code.
- R12: `rot_fwd` resets to 1. It becomes 1 when a valid change moves the sector up by one (mod 6) and 0 when it moves down by one. Any other change leaves it unchanged.
- R13: During reset and until the first accepted code, all gates are off, both flags are clear, `sector` is 0 and `rot_fwd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_in | input | 3 | Raw Hall sensor levels, asynchronous |
| dir_rev | input | 1 | 1 = drive in reverse |
| enable | input | 1 | 0 forces all gates off |
| pwm_in | input | 1 | Chopping signal for the active high-side switch |
| sec_ofs | input | 3 | Sensor alignment offset in sectors |
| gate_hi | output | 3 | High-side gate commands, bits A, B, C |
| gate_lo | output | 3 | Low-side gate commands, bits A, B, C |
| sector | output | 3 | Last decoded valid sector |
| sector_chg | output | 1 | One-clock pulse per accepted sector change |
| rot_fwd | output | 1 | Observed rotation direction, 1 = forward |
| hall_fault | output | 1 | Sticky forbidden-pattern flag |
| seq_err | output | 1 | Sticky skipped-sector flag |

## Verification
The assertions assume that `sec_ofs` and `dir_rev` are static settings. They also assume that any Hall level meant as a real sector change is held well beyond the filter window, so that accepted changes are separated by several clocks and the one-clock change pulse never merges with the next one. The stimulus holds every new Hall level, offset or direction for sixteen clocks before any output is compared. The only shorter Hall excursion it applies is a deliberate two-clock glitch, which is expected to be rejected.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
  localparam int NSEC = 6;
  typedef logic [2:0] sec_t;

  function automatic logic code_ok(input logic [2:0] c);
    return (c != 3'b000) && (c != 3'b111);
  endfunction

  function automatic sec_t code_to_sec(input logic [2:0] c);
    sec_t s;
    case (c)
      3'b001:  s = 3'd0;
      3'b011:  s = 3'd1;
      3'b010:  s = 3'd2;
      3'b110:  s = 3'd3;
      3'b100:  s = 3'd4;
      3'b101:  s = 3'd5;
      default: s = 3'd0;
    endcase
    return s;
  endfunction

  function automatic sec_t sec_add(input sec_t a, input sec_t b);
    logic [3:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= 4'(NSEC)) t = t - 4'(NSEC);
    return t[2:0];
  endfunction

  function automatic sec_t sec_norm(input sec_t a);
    return (a >= 3'(NSEC)) ? a - 3'(NSEC) : a;
  endfunction

  function automatic logic multi_flip(input logic [2:0] a, input logic [2:0] b);
    logic [2:0] x;
    x = a ^ b;
    return (x & (x - 3'd1)) != 3'd0;
  endfunction
endpackage

// File: rtl/hcm_hall_filter.sv
module hcm_hall_filter #(
  parameter int W           = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hall_raw,
  output logic [W-1:0] hall_f,
  output logic         locked
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

  logic [W-1:0]  sq [SYNC_STAGES];
  logic [W-1:0]  cand;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= '0;
    end else begin
      sq[0] <= hall_raw;
      for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand   <= '0;
      cnt    <= '0;
      hall_f <= '0;
      locked <= 1'b0;
    end else if (sq[SYNC_STAGES-1] != cand) begin
      cand <= sq[SYNC_STAGES-1];
      cnt  <= '0;
    end else if (cnt < LIM) begin
      cnt <= cnt + 1'b1;
    end else begin
      hall_f <= cand;
      locked <= 1'b1;
    end
  end

  // R1
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_f != $past(hall_f)) |-> ($past(cand) == hall_f && $past(cnt) == LIM));
endmodule

// File: rtl/hcm_decode.sv
module hcm_decode
  import hcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_f,
  input  logic       locked,
  output sec_t       sector,
  output logic       code_valid,
  output logic       sec_chg,
  output logic       rot_fwd,
  output logic       fault,
  output logic       seq_err
);
  logic [2:0] prev_code;
  sec_t       new_sec, old_sec;

  always_comb begin
    new_sec = code_to_sec(hall_f);
    old_sec = code_to_sec(prev_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code  <= 3'b000;
      sector     <= '0;
      code_valid <= 1'b0;
      sec_chg    <= 1'b0;
      rot_fwd    <= 1'b1;
      fault      <= 1'b0;
      seq_err    <= 1'b0;
    end else begin
      sec_chg    <= 1'b0;
      code_valid <= locked && code_ok(hall_f);
      if (locked) begin
        if (!code_ok(hall_f)) fault <= 1'b1;
        if (code_ok(hall_f)) sector <= new_sec;
        if (hall_f != prev_code) begin
          prev_code <= hall_f;
          if (code_ok(hall_f) && code_ok(prev_code)) begin
            sec_chg <= 1'b1;
            if (multi_flip(hall_f, prev_code)) seq_err <= 1'b1;
            if (new_sec == sec_add(old_sec, 3'd1))      rot_fwd <= 1'b1;
            else if (new_sec == sec_add(old_sec, 3'd5)) rot_fwd <= 1'b0;
          end
        end
      end
    end
  end

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  // R9
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !code_ok(hall_f)) |=> fault);
  // R10
  seq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
  // R11
  chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_chg |=> !sec_chg);
endmodule

// File: rtl/hcm_bridge.sv
module hcm_bridge
  import hcm_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  sec_t           sector,
  input  logic           code_valid,
  input  logic           fault,
  input  logic           enable,
  input  logic           dir_rev,
  input  logic [2:0]     sec_ofs,
  input  logic           pwm_in,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  localparam int PW = $clog2(NPH);

  sec_t           state;
  logic [PW-1:0]  hi_ph, lo_ph;
  logic           drive;
  logic [NPH-1:0] hi_n, lo_n;

  always_comb begin
    state = sec_add(sec_add(sector, sec_norm(sec_ofs)), dir_rev ? 3'd3 : 3'd0);
    drive = enable && code_valid && !fault;
    case (state)
      3'd0:    begin hi_ph = PW'(0); lo_ph = PW'(1); end
      3'd1:    begin hi_ph = PW'(0); lo_ph = PW'(2); end
      3'd2:    begin hi_ph = PW'(1); lo_ph = PW'(2); end
      3'd3:    begin hi_ph = PW'(1); lo_ph = PW'(0); end
      3'd4:    begin hi_ph = PW'(2); lo_ph = PW'(0); end
      default: begin hi_ph = PW'(2); lo_ph = PW'(1); end
    endcase
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign hi_n[p] = drive && pwm_in && (hi_ph == PW'(p));
    assign lo_n[p] = drive && (lo_ph == PW'(p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= '0;
      gate_lo <= '0;
    end else begin
      gate_hi <= hi_n;
      gate_lo <= lo_n;
    end
  end

  // R5
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);
  // R5
  one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_hi) && $onehot0(gate_lo));
  // R6
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (gate_hi == '0 && gate_lo == '0));
  // R4
  pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |=> gate_hi == '0);
  // R9
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_rev,
  input  logic       enable,
  input  logic       pwm_in,
  input  logic [2:0] sec_ofs,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic [2:0] sector,
  output logic       sector_chg,
  output logic       rot_fwd,
  output logic       hall_fault,
  output logic       seq_err
);
  logic [2:0] hall_f;
  logic       locked;
  logic       code_valid;
  sec_t       sec_q;

  hcm_hall_filter #(
    .W(3), .SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .hall_raw(hall_in),
    .hall_f(hall_f), .locked(locked)
  );

  hcm_decode u_dec (
    .clk(clk), .rst_n(rst_n), .hall_f(hall_f), .locked(locked),
    .sector(sec_q), .code_valid(code_valid), .sec_chg(sector_chg),
    .rot_fwd(rot_fwd), .fault(hall_fault), .seq_err(seq_err)
  );

  hcm_bridge #(.NPH(3)) u_brg (
    .clk(clk), .rst_n(rst_n), .sector(sec_q), .code_valid(code_valid),
    .fault(hall_fault), .enable(enable), .dir_rev(dir_rev),
    .sec_ofs(sec_ofs), .pwm_in(pwm_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  assign sector = sec_q;
endmodule

// File: tb/hall_commutator_bench.sv
module hall_commutator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_in = 3'b001;
  logic       dir_rev = 1'b0, enable = 1'b1, pwm_in = 1'b1;
  logic [2:0] sec_ofs = 3'd0;
  logic [2:0] gate_hi, gate_lo, sector;
  logic       sector_chg, rot_fwd, hall_fault, seq_err;

  int checks = 0, errors = 0, chg_cnt = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] hi, lo, sec;
    logic       flt, serr, fwd;
    string      tag;
  } item_t;
  item_t q[$];

  logic [2:0] m_prev = 3'b000;
  logic       m_fault = 0, m_seq = 0, m_fwd = 1;
  int         m_sec = 0;

  always #10 clk = ~clk;

  hall_commutator u_hall_commutator (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
    .enable(enable), .pwm_in(pwm_in), .sec_ofs(sec_ofs),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .sector(sector),
    .sector_chg(sector_chg), .rot_fwd(rot_fwd),
    .hall_fault(hall_fault), .seq_err(seq_err)
  );

  always @(negedge clk) if (sector_chg) chg_cnt++;

  function automatic bit vld(input logic [2:0] c);
    return c != 3'b000 && c != 3'b111;
  endfunction

  function automatic int sec_of(input logic [2:0] c);
    int t[8] = '{0, 0, 2, 1, 4, 5, 3, 0};
    return t[c];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_hall(input logic [2:0] h);
    int ns, os;
    if (h == m_prev) return;
    ns = sec_of(h);
    os = sec_of(m_prev);
    if (vld(h) && vld(m_prev)) begin
      if ($countones(h ^ m_prev) > 1) m_seq = 1;
      if (ns == (os + 1) % 6) m_fwd = 1;
      else if (ns == (os + 5) % 6) m_fwd = 0;
    end
    if (!vld(h)) m_fault = 1;
    else m_sec = ns;
    m_prev = h;
  endtask

  task automatic settle_push(input string tag);
    item_t it;
    int hp[6] = '{0, 0, 1, 1, 2, 2};
    int lp[6] = '{1, 2, 2, 0, 0, 1};
    int o, s;
    repeat (16) @(negedge clk);
    it.hi = 3'b000;
    it.lo = 3'b000;
    if (enable && !m_fault && vld(m_prev)) begin
      o = (sec_ofs > 5) ? int'(sec_ofs) - 6 : int'(sec_ofs);
      s = (m_sec + o + (dir_rev ? 3 : 0)) % 6;
      it.hi = pwm_in ? 3'(1 << hp[s]) : 3'b000;
      it.lo = 3'(1 << lp[s]);
    end
    it.sec = 3'(m_sec);
    it.flt = m_fault;
    it.serr = m_seq;
    it.fwd = m_fwd;
    it.tag = tag;
    q.push_back(it);
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic [2:0] h, input string tag);
    hall_in = h;
    model_hall(h);
    settle_push(tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(gate_hi == it.hi, {it.tag, " gate_hi"}, gate_hi, it.hi);
        chk(gate_lo == it.lo, {it.tag, " gate_lo"}, gate_lo, it.lo);
        chk(sector == it.sec, {it.tag, " sector"}, sector, it.sec);
        chk(hall_fault == it.flt, {it.tag, " hall_fault"}, hall_fault, it.flt);
        chk(seq_err == it.serr, {it.tag, " seq_err"}, seq_err, it.serr);
        chk(rot_fwd == it.fwd, {it.tag, " rot_fwd"}, rot_fwd, it.fwd);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int c0;
    logic [2:0] fwd_seq[6] = '{3'b011, 3'b010, 3'b110, 3'b100, 3'b101, 3'b001};
    logic [2:0] rev_seq[2] = '{3'b100, 3'b110};

    repeat (4) @(negedge clk);
    // R13: reset state
    chk(gate_hi == 0 && gate_lo == 0, "R13 gates in reset", {gate_hi, gate_lo}, 0);
    chk(!hall_fault && !seq_err && rot_fwd && sector == 0, "R13 status in reset",
        {hall_fault, seq_err, rot_fwd, sector}, 6'b001000);
    rst_n = 1'b1;

    // R1 R2 R3: first lock on 001
    model_hall(3'b001);
    settle_push("R2 R3 lock");

    // R2 R3 R11 R12: forward walk
    c0 = chg_cnt;
    foreach (fwd_seq[i]) step(fwd_seq[i], "R2 R3 R12 fwd walk");
    chk(chg_cnt - c0 == 6, "R11 pulses on fwd walk", chg_cnt - c0, 6);

    // R4: PWM low leaves low side on
    pwm_in = 1'b0;
    settle_push("R4 pwm low");
    pwm_in = 1'b1;

    // R7: reverse drive, then backward walk for R12
    dir_rev = 1'b1;
    settle_push("R7 reverse");
    step(3'b101, "R7 R12 back step");
    foreach (rev_seq[i]) step(rev_seq[i], "R12 back walk");
    dir_rev = 1'b0;
    settle_push("R3 fwd again");

    // R8: offsets
    sec_ofs = 3'd2;
    settle_push("R8 offset 2");
    sec_ofs = 3'd7;
    settle_push("R8 offset 7");
    sec_ofs = 3'd0;

    // R6: enable low
    enable = 1'b0;
    settle_push("R6 disabled");
    enable = 1'b1;
    settle_push("R6 re-enabled");

    // R1: two-clock glitch ignored
    c0 = chg_cnt;
    hall_in = 3'b010;
    repeat (2) @(negedge clk);
    hall_in = 3'b110;
    settle_push("R1 glitch rejected");
    chk(chg_cnt == c0, "R1 R11 no pulse on glitch", chg_cnt - c0, 0);

    // R10: skip two sectors 110 -> 101 is 3->5, two bits
    c0 = chg_cnt;
    step(3'b101, "R10 skipped sector");
    chk(chg_cnt - c0 == 1, "R11 pulse on skip", chg_cnt - c0, 1);

    // R9: invalid code then valid again
    c0 = chg_cnt;
    step(3'b111, "R9 invalid code");
    step(3'b001, "R9 sticky after recovery");
    chk(chg_cnt == c0, "R11 no pulse via invalid", chg_cnt - c0, 0);

    // R13: reset clears flags
    rst_n = 1'b0;
    m_prev = 3'b000; m_fault = 0; m_seq = 0; m_fwd = 1; m_sec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_hall(3'b001);
    settle_push("R13 cleared after reset");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule